// File: doc/BRIEF.md
# Serial EEPROM Slave Interface

This block is the slave side of a four-wire serial memory link in front of a 1024 x 8 byte store. The host selects it with an active-low chip select, shifts an 8-bit command in most significant bit first, and for memory commands follows it with a 16-bit address. Reads stream bytes back for as long as the serial clock runs. Writes collect up to one page of data in a local buffer. The buffer is copied into the store only when chip select is released cleanly on a byte boundary. The block also holds a write-enable latch and a three-bit lock code. A separate policy block turns the lock code into per-address write permission.

The serial clock, chip select and data input are sampled by a faster system clock and edge-detected, so every register sits in one clock domain. Each serial clock phase must last at least four system clock periods. The data output is not tristated here. Instead the block provides a data bit and an enable, and the pad driver combines them. During a commit the block walks the buffered page one byte per cycle. It presents each address on `chk_addr` and writes that byte only if `chk_permit` is high in the same cycle. A programmable busy time follows the walk, and during it only the status command is serviced.

Command codes: 0x06 sets the write-enable latch, 0x04 clears it, 0x01 sets the lock code, 0x05 reads status, 0x02 writes, 0x03 reads.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, `lock_bits` is 0, the write-enable latch is clear and the block is not busy.
- R2: Input bits are taken on rising serial clock edges. The data output changes only after a falling edge. The output enable is low whenever chip select is high.
- R3: Command 0x03 followed by a 16-bit address, of which bits 9:0 are used, returns the addressed byte MSB first. Further bytes follow at increasing addresses while the clock runs, and address 0x3FF is followed by 0x000.
- R4: Command 0x02 followed by a 16-bit address and data bytes stores the bytes at successive addresses. Only address bits 3:0 advance, so the bytes wrap within the 16-byte page and a later byte overwrites an earlier one at the same offset.
- R5: A write is committed only if chip select rises after at least one complete data byte and no partial bits. Otherwise nothing is stored.
- R6: Command 0x06 sets the write-enable latch and 0x04 clears it. Each takes effect only if chip select rises after exactly 8 clocks. A write or lock-set command is ignored while the latch is clear, and a committed write or lock-set clears the latch.
- R7: Command 0x05 returns 0xFF while a commit or its busy time is in progress. Otherwise it returns the lock code in bits 2:0 with bits 7:3 zero, and the byte repeats every 8 clocks.
- R8: Command 0x01 followed by data bytes sets `lock_bits` to bits 2:0 of the last complete byte when chip select rises on a byte boundary. The change starts the busy time, and an incomplete final byte discards the whole command.
- R9: During a commit each buffered byte is written only if `chk_permit` is high while `chk_addr` shows that byte's address.
- R10: While busy, commands 0x03, 0x02 and 0x01 are ignored. The output stays disabled and memory is unchanged.
- R11: An unknown command is ignored until chip select rises, and the output stays disabled meanwhile.
- R12: After reset no command is accepted until chip select has gone from high to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for the data-out pad |
| lock_bits | output | 3 | Current lock code for the policy block |
| chk_addr | output | 10 | Address offered to the policy block during a commit |
| chk_permit | input | 1 | Policy answer: the address on chk_addr may be written |

## Verification
On every cycle, the assertions check the following:
- the output is disabled a few cycles after chip select goes high;
- the output bit moves only after a detected falling edge;
- a commit walk starts only with the write-enable latch set, and clears it;
- the lock code changes only at the start of a busy period;
- no read or address phase overlaps busy time.

Data ordering, page wrap, array wrap, boundary-exact commit, permission gating and the handling of unknown commands show only in the bench's transactions. The bench checks them by writing through the serial port and reading the results back.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_en,
  output logic [2:0]        lock_bits,
  output logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_permit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam int SR_W  = (ADDR_W - 1 > 7) ? ADDR_W - 1 : 7;

  localparam logic [7:0] OP_WEN = 8'h06, OP_WDI = 8'h04, OP_LCK = 8'h01,
                         OP_STA = 8'h05, OP_WR  = 8'h02, OP_RD  = 8'h03;

  localparam logic [3:0] S_IDLE = 4'd0, S_OPC = 4'd1, S_WEN = 4'd2, S_WDI = 4'd3,
                         S_ADR  = 4'd4, S_RD  = 4'd5, S_WR  = 4'd6, S_LCK = 4'd7,
                         S_ST   = 4'd8, S_IGN = 4'd9;

  logic [2:0]        cs_s, sck_s;
  logic [1:0]        si_s;
  logic [3:0]        state;
  logic [SR_W-1:0]   shreg;
  logic [2:0]        bitcnt;
  logic              hi, rd_op, wel, have, cmt_act, so_q;
  logic [PAGE_W-1:0] cmt_idx;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        lk_byte, lock;
  logic [TW-1:0]     timer;
  logic [PAGE-1:0]   pmask;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        mem_q;

  wire cs_low   = ~cs_s[1];
  wire cs_fall  =  cs_s[2] & ~cs_s[1];
  wire cs_rise  = ~cs_s[2] &  cs_s[1];
  wire sck_rise = cs_low &  sck_s[1] & ~sck_s[2];
  wire sck_fall = cs_low & ~sck_s[1] &  sck_s[2];
  wire shift_en = sck_rise & ~cs_fall;
  wire si_b     = si_s[1];
  wire busy     = cmt_act | (timer != '0);
  wire [7:0] rx_byte = {shreg[6:0], si_b};
  wire [7:0] stat_w  = {5'b0, lock};
  wire mem_we   = cmt_act & pmask[cmt_idx] & chk_permit;

  assign chk_addr  = {addr[ADDR_W-1:PAGE_W], cmt_idx};
  assign so        = so_q;
  assign so_en     = (state == S_RD) || (state == S_ST);
  assign lock_bits = lock;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_s <= '0; sck_s <= '0; si_s <= '0;
    end else begin
      cs_s  <= {cs_s[1:0], cs_n};
      sck_s <= {sck_s[1:0], sck};
      si_s  <= {si_s[0], si};
    end

  always_ff @(posedge clk) begin
    if (mem_we) mem[chk_addr] <= pbuf[cmt_idx];
    mem_q <= mem[addr];
  end

  always_ff @(posedge clk)
    if (shift_en && state == S_WR && bitcnt == 3'd7)
      pbuf[addr[PAGE_W-1:0]] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; shreg <= '0; bitcnt <= '0; hi <= 1'b0; rd_op <= 1'b0;
      wel <= 1'b0; have <= 1'b0; cmt_act <= 1'b0; cmt_idx <= '0; addr <= '0;
      lk_byte <= '0; lock <= '0; timer <= '0; pmask <= '0; so_q <= 1'b0;
    end else begin
      if (cmt_act) begin
        cmt_idx <= cmt_idx + 1'b1;
        if (&cmt_idx) begin
          cmt_act <= 1'b0;
          timer   <= TW'(WR_CYCLES);
        end
      end else if (timer != '0) begin
        timer <= timer - 1'b1;
      end

      if (cs_fall) begin
        state <= S_OPC; bitcnt <= '0; hi <= 1'b0; have <= 1'b0;
      end else if (cs_rise) begin
        case (state)
          S_WEN: if (bitcnt == 3'd0) wel <= 1'b1;
          S_WDI: if (bitcnt == 3'd0) wel <= 1'b0;
          S_WR:  if (bitcnt == 3'd0 && have) begin
                   cmt_act <= 1'b1; cmt_idx <= '0; wel <= 1'b0;
                 end
          S_LCK: if (bitcnt == 3'd0 && have) begin
                   lock <= lk_byte; timer <= TW'(WR_CYCLES); wel <= 1'b0;
                 end
          default: ;
        endcase
        state <= S_IDLE;
      end else if (shift_en && state != S_IDLE) begin
        shreg  <= {shreg[SR_W-2:0], si_b};
        bitcnt <= bitcnt + 1'b1;
        case (state)
          S_OPC: if (bitcnt == 3'd7) begin
            case (rx_byte)
              OP_WEN: state <= S_WEN;
              OP_WDI: state <= S_WDI;
              OP_STA: state <= S_ST;
              OP_RD:  begin state <= busy ? S_IGN : S_ADR; rd_op <= 1'b1; end
              OP_WR:  begin state <= (busy || !wel) ? S_IGN : S_ADR; rd_op <= 1'b0; end
              OP_LCK: state <= (busy || !wel) ? S_IGN : S_LCK;
              default: state <= S_IGN;
            endcase
          end
          S_WEN, S_WDI: state <= S_IGN;
          S_ADR: if (bitcnt == 3'd7) begin
            hi <= 1'b1;
            if (hi) begin
              addr  <= {shreg[ADDR_W-2:0], si_b};
              state <= rd_op ? S_RD : S_WR;
              have  <= 1'b0;
              pmask <= '0;
            end
          end
          S_RD: if (bitcnt == 3'd7) addr <= addr + 1'b1;
          S_WR: if (bitcnt == 3'd7) begin
            pmask[addr[PAGE_W-1:0]] <= 1'b1;
            addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
            have                    <= 1'b1;
          end
          S_LCK: if (bitcnt == 3'd7) begin
            lk_byte <= rx_byte[2:0];
            have    <= 1'b1;
          end
          default: ;
        endcase
      end

      if (sck_fall && !cs_fall) begin
        if (state == S_RD) so_q <= mem_q[~bitcnt];
        else if (state == S_ST) so_q <= busy | stat_w[~bitcnt];
      end
    end
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_en,
  input logic       so,
  input logic       sck_fall,
  input logic       wel,
  input logic       cmt_act,
  input logic       busy,
  input logic       rd_or_adr,
  input logic [2:0] lock_bits
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;

  p_so_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_en);

  p_so_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !$stable(so)) |-> $past(sck_fall));

  p_commit_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && $rose(cmt_act)) |-> ($past(wel) && !wel));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_or_adr |-> !busy);

  p_lock_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !$stable(lock_bits)) |-> (busy && !$past(busy)));
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_en(so_en), .so(so),
  .sck_fall(sck_fall), .wel(wel), .cmt_act(cmt_act), .busy(busy),
  .rd_or_adr((state == S_ADR) || (state == S_RD)), .lock_bits(lock_bits)
);

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;
  localparam int HALF = 4;
  localparam int WRC  = 2000;
  localparam logic [17:0] VEC [6] = '{
    {10'h3FF, 8'hC3}, {10'h000, 8'h81}, {10'h155, 8'hA5},
    {10'h2A0, 8'h4E}, {10'h0F0, 8'h0F}, {10'h1FF, 8'h7E}};

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, si = 1'b0;
  logic so, so_en, chk_permit;
  logic [2:0] lock_bits;
  logic [9:0] chk_addr;
  int errors = 0, checks = 0, cyc = 0;
  logic en_seen;
  logic [7:0] rx;

  always #5 clk = ~clk;

  always_comb
    case (lock_bits)
      3'd1: chk_permit = chk_addr[9:8] != 2'd0;
      3'd2: chk_permit = chk_addr[9:8] != 2'd1;
      3'd3: chk_permit = chk_addr[9:8] != 2'd2;
      3'd4: chk_permit = chk_addr[9:8] != 2'd3;
      3'd5: chk_permit = !(chk_addr[9] == 1'b0);
      3'd6: chk_permit = chk_addr[9:4] != 6'h00;
      3'd7: chk_permit = chk_addr[9:4] != 6'h3F;
      default: chk_permit = 1'b1;
    endcase

  spi_eeprom_slave #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .so_en(so_en), .lock_bits(lock_bits), .chk_addr(chk_addr), .chk_permit(chk_permit));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog (all R): actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    en_seen = en_seen | so_en;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], r[i]);
  endtask

  task automatic t_begin();
    en_seen = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    t_begin(); byte_x(op, d); t_end();
  endtask

  task automatic hdr(input logic [7:0] op, input logic [9:0] a);
    logic [7:0] d;
    byte_x(op, d); byte_x({6'b0, a[9:8]}, d); byte_x(a[7:0], d);
  endtask

  task automatic write1(input logic [9:0] a, input logic [7:0] v);
    logic [7:0] d;
    t_begin(); hdr(8'h02, a); byte_x(v, d); t_end();
  endtask

  task automatic read1(input logic [9:0] a, output logic [7:0] v);
    t_begin(); hdr(8'h03, a); byte_x(8'h00, v); t_end();
  endtask

  task automatic status(output logic [7:0] v);
    logic [7:0] d;
    t_begin(); byte_x(8'h05, d); byte_x(8'h00, v); t_end();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int n = 0; n < 100; n++) begin
      status(s);
      if (s != 8'hFF) break;
    end
  endtask

  initial begin
    logic [7:0] d;
    logic b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 so_en after reset", {7'b0, so_en}, 8'h00);
    chk("R1 lock_bits after reset", {5'b0, lock_bits}, 8'h00);

    en_seen = 1'b0;
    byte_x(8'h05, d); byte_x(8'h00, d);
    chk("R12 no command before CS falls", {7'b0, en_seen}, 8'h00);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    chk("R2 so_en with CS high", {7'b0, so_en}, 8'h00);

    for (int k = 0; k < 6; k++) begin
      cmd1(8'h06);
      write1(VEC[k][17:8], VEC[k][7:0]);
      wait_ready();
      read1(VEC[k][17:8], d);
      chk("R3 R4 table read-back", d, VEC[k][7:0]);
    end

    t_begin(); hdr(8'h03, 10'h3FF); byte_x(8'h00, d);
    chk("R3 stream first byte", d, 8'hC3);
    byte_x(8'h00, d);
    chk("R3 wrap 3FF to 000", d, 8'h81);
    t_end();
    chk("R2 so_en after CS high", {7'b0, so_en}, 8'h00);

    cmd1(8'h06);
    t_begin(); hdr(8'h02, 10'h0AE);
    for (int i = 0; i < 18; i++) byte_x(8'h40 + 8'(i), d);
    t_end();
    wait_ready();
    t_begin(); hdr(8'h03, 10'h0A0);
    for (int k = 0; k < 16; k++) begin
      byte_x(8'h00, d);
      chk("R4 page wrap", d, (k < 14) ? 8'h42 + 8'(k) : 8'h50 + 8'(k - 14));
    end
    t_end();

    cmd1(8'h06);
    t_begin(); hdr(8'h02, 10'h155); byte_x(8'h77, d);
    for (int i = 0; i < 4; i++) bit_x(1'b0, b);
    t_end();
    status(d);
    chk("R5 partial byte not committed (idle)", d, 8'h00);
    read1(10'h155, d);
    chk("R5 partial byte not stored", d, 8'hA5);
    t_begin(); hdr(8'h02, 10'h155); t_end();
    status(d);
    chk("R5 no data bytes not committed", d, 8'h00);

    cmd1(8'h04);
    write1(10'h155, 8'h99);
    status(d);
    chk("R6 write after WRDI ignored (idle)", d, 8'h00);
    read1(10'h155, d);
    chk("R6 write after WRDI ignored", d, 8'hA5);
    cmd1(8'h06);
    write1(10'h2A0, 8'h11);
    wait_ready();
    write1(10'h2A0, 8'h22);
    wait_ready();
    read1(10'h2A0, d);
    chk("R6 latch cleared by commit", d, 8'h11);
    t_begin(); byte_x(8'h06, d); byte_x(8'h00, d); t_end();
    write1(10'h2A0, 8'h33);
    wait_ready();
    read1(10'h2A0, d);
    chk("R6 WREN with extra clocks ignored", d, 8'h11);

    cmd1(8'h06);
    write1(10'h155, 8'h3C);
    status(d);
    chk("R7 status while busy", d, 8'hFF);
    read1(10'h155, d);
    chk("R10 read ignored while busy", {7'b0, en_seen}, 8'h00);
    cmd1(8'h06);
    write1(10'h0F0, 8'hEE);
    wait_ready();
    status(d);
    chk("R7 status idle", d, 8'h00);
    read1(10'h155, d);
    chk("R4 write committed", d, 8'h3C);
    read1(10'h0F0, d);
    chk("R10 write ignored while busy", d, 8'h0F);

    t_begin(); byte_x(8'hAB, d); byte_x(8'h00, d); byte_x(8'h00, d); t_end();
    chk("R11 unknown opcode keeps SO off", {7'b0, en_seen}, 8'h00);

    cmd1(8'h04);
    cmd1(8'h06);
    t_begin(); byte_x(8'h01, d); byte_x(8'h06, d); t_end();
    wait_ready();
    chk("R8 lock set", {5'b0, lock_bits}, 8'h06);
    status(d);
    chk("R7 status shows lock", d, 8'h06);
    cmd1(8'h06);
    write1(10'h000, 8'h5A);
    wait_ready();
    read1(10'h000, d);
    chk("R9 blocked address unchanged", d, 8'h81);
    cmd1(8'h06);
    write1(10'h010, 8'h61);
    wait_ready();
    read1(10'h010, d);
    chk("R9 permitted address written", d, 8'h61);
    cmd1(8'h06);
    t_begin(); byte_x(8'h01, d); byte_x(8'h00, d);
    for (int i = 0; i < 3; i++) bit_x(1'b0, b);
    t_end();
    chk("R8 partial lock discarded", {5'b0, lock_bits}, 8'h06);
    cmd1(8'h06);
    t_begin(); byte_x(8'h01, d); byte_x(8'h07, d); byte_x(8'h00, d); t_end();
    chk("R8 last lock byte wins", {5'b0, lock_bits}, 8'h00);
    wait_ready();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule